// File: doc/BRIEF.md
# Variable-Frequency Phase Accumulator Generator

This block is a numerically controlled oscillator. It runs from a fixed reference clock, nominally 27 MHz. A 16-bit tuning word sets the rate at which a 16-bit phase accumulator advances. The accumulator's top bit is brought out as a square wave. A one-cycle tick marks every rising edge of that square wave, so a downstream PWM stage can use it as a clock enable. The output frequency is the effective increment times the reference frequency divided by 2^16.

The tuning word is not used as it stands. When its top bit is clear, the effective increment is the word itself. When the top bit is set, the increment is the 16-bit two's complement of the word, so words above half scale mirror back down. The word arrives one byte at a time. A high-byte write only stages the byte. A low-byte write commits the whole word at once, so the accumulator never runs on a half-updated word. A run input starts the accumulator; while it is low the accumulator is held at zero. A synchronous reset clears everything.

A power-of-two word gives a square wave with 50% duty, which is the form a following stage wants as its clock. In that use the word stays between 1 and 32768.

Top module: `nco_vargen`

## Requirements
- R1: After a synchronous reset, `sq_out` and `tick` are 0 and the committed tuning word is 0. Running with no word written leaves both outputs at 0.
- R2: A cycle with `hi_wr`=1 and `lo_wr`=0 stores `wr_data` as the staged high byte. The increment in use stays the same.
- R3: A cycle with `lo_wr`=1 commits the word {staged high byte, `wr_data`}, high byte in bits 15:8 and low byte in bits 7:0. The accumulator first uses the new increment at the clock edge after the commit edge.
- R4: The effective increment is the word itself when bit 15 is 0. Otherwise it is (2^16 − word) mod 2^16. Examples: 0xC000 and 0x4000 both step by 0x4000, 0x8000 steps by 0x8000, and 0xFFFF steps by 1.
- R5: While `run`=1, the accumulator adds the increment modulo 2^16 at every clock edge, and `sq_out` equals the accumulator's bit 15.
- R6: A clock edge with `run`=0 sets the accumulator to 0, so `sq_out` and `tick` are 0 in the following cycle.
- R7: `tick` is 1 for exactly the cycles in which `sq_out` is 1 after being 0 in the previous cycle. It is never 1 for two cycles in a row.
- R8: A power-of-two word 2^k gives a square wave with a period of 2^(16−k) cycles, half of them high. For example, 0x4000 gives 2 cycles high and 2 low.
- R9: When `hi_wr` and `lo_wr` are both 1 in the same cycle, only the commit happens. It uses the high byte staged earlier, and `wr_data` does not become the new staged high byte.
- R10: The synchronous reset also clears the staged high byte. A low-byte write just after reset therefore commits {0x00, `wr_data`}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Accumulator advances when 1, held at zero when 0 |
| hi_wr | input | 1 | Stage `wr_data` as the tuning word's high byte |
| lo_wr | input | 1 | Commit {staged high, `wr_data`} as the tuning word |
| wr_data | input | 8 | Byte being written |
| sq_out | output | 1 | Square wave, accumulator bit 15 |
| tick | output | 1 | One-cycle pulse on each rising edge of `sq_out` |

## Verification
The bench targets the fold at its edges:
- 0x8000 must toggle every cycle; a design that negated it to zero, or sign-extended it, would freeze or drift.
- 0xFFFF must step by 1; a design that used the raw word would step by −1 and run the square wave backwards.

It writes a high byte while running and checks that the rate does not change. A design that committed on the high byte would jump to a half-updated rate. It asserts both strobes at once and checks that the old staged byte is kept. It resets between a high write and a low write, and a design that kept the staged byte through reset would commit the wrong word. Stopping mid-cycle must clear the phase. A design that only froze it would resume with the wrong phase and emit an early or missing tick.

// File: rtl/nco_pkg.sv
package nco_pkg;

  typedef enum logic [1:0] {
    WR_IDLE   = 2'd0,
    WR_STAGE  = 2'd1,
    WR_COMMIT = 2'd2
  } wr_kind_e;

  function automatic wr_kind_e decode_write(input logic hi_wr, input logic lo_wr);
    if (lo_wr)      return WR_COMMIT;
    else if (hi_wr) return WR_STAGE;
    else            return WR_IDLE;
  endfunction

endpackage

// File: rtl/nco_word_stage.sv
module nco_word_stage #(
  parameter int WORD_W = 16,
  localparam int BYTE_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hi_wr,
  input  logic              lo_wr,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [WORD_W-1:0] word
);
  import nco_pkg::*;

  logic [BYTE_W-1:0] staged_hi;
  wr_kind_e          wr_kind;

  assign wr_kind = decode_write(hi_wr, lo_wr);

  always_ff @(posedge clk) begin
    if (rst) begin
      staged_hi <= '0;
      word      <= '0;
    end else begin
      case (wr_kind)
        WR_STAGE:  staged_hi <= wr_byte;
        WR_COMMIT: word      <= {staged_hi, wr_byte};
        default: ;
      endcase
    end
  end

  assert_reset_word_R1: assert property (@(posedge clk)
    rst |=> (word == '0));

  assert_reset_stage_R10: assert property (@(posedge clk)
    rst |=> (staged_hi == '0));

  assert_hi_holds_word_R2: assert property (@(posedge clk) disable iff (rst)
    (hi_wr && !lo_wr) |=> $stable(word));

  assert_commit_R3: assert property (@(posedge clk) disable iff (rst)
    lo_wr |=> (word == {$past(staged_hi), $past(wr_byte)}));

  assert_both_keep_stage_R9: assert property (@(posedge clk) disable iff (rst)
    (hi_wr && lo_wr) |=> $stable(staged_hi));

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] phase,
  output logic [WORD_W-1:0] step
);
  localparam logic [WORD_W-1:0] HALF = {1'b1, {(WORD_W-1){1'b0}}};

  function automatic logic [WORD_W-1:0] fold_step(input logic [WORD_W-1:0] w);
    if (w[WORD_W-1]) return (~w) + 1'b1;
    else             return w;
  endfunction

  assign step = fold_step(word);

  always_ff @(posedge clk) begin
    if (rst)       phase <= '0;
    else if (!run) phase <= '0;
    else           phase <= phase + step;
  end

  assert_step_range_R4: assert property (@(posedge clk) disable iff (rst)
    step <= HALF);

  assert_stop_zero_R6: assert property (@(posedge clk) disable iff (rst)
    !run |=> (phase == '0));

  assert_reset_phase_R1: assert property (@(posedge clk)
    rst |=> (phase == '0));

endmodule

// File: rtl/nco_edge_tick.sv
module nco_edge_tick (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic pulse
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level;
  end

  assign pulse = level & ~level_q;

  assert_tick_single_R7: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);

endmodule

// File: rtl/nco_vargen.sv
module nco_vargen #(
  parameter int WORD_W = 16,
  localparam int BYTE_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              hi_wr,
  input  logic              lo_wr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              sq_out,
  output logic              tick
);
  logic [WORD_W-1:0] word_live;
  logic [WORD_W-1:0] phase_now;
  logic [WORD_W-1:0] step_now;
  logic              phase_msb;

  nco_word_stage #(.WORD_W(WORD_W)) u_word (
    .clk     (clk),
    .rst     (rst),
    .hi_wr   (hi_wr),
    .lo_wr   (lo_wr),
    .wr_byte (wr_data),
    .word    (word_live)
  );

  nco_phase_acc #(.WORD_W(WORD_W)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .run   (run),
    .word  (word_live),
    .phase (phase_now),
    .step  (step_now)
  );

  assign phase_msb = phase_now[WORD_W-1];

  nco_edge_tick u_tick (
    .clk   (clk),
    .rst   (rst),
    .level (phase_msb),
    .pulse (tick)
  );

  assign sq_out = phase_msb;

  assert_tick_on_rise_R7: assert property (@(posedge clk) disable iff (rst)
    tick |-> (sq_out && !$past(sq_out)));

  assert_stopped_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!sq_out && !tick));

  assert_stepping_R5: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |-> (phase_now == $past(phase_now) + $past(step_now)));

endmodule

// File: tb/sim_nco_vargen.sv
`timescale 1ns/1ps
module sim_nco_vargen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run = 1'b0;
  logic       hi_wr = 1'b0;
  logic       lo_wr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       sq_out;
  logic       tick;

  always #5 clk = ~clk;

  nco_vargen u0 (
    .clk(clk), .rst(rst), .run(run), .hi_wr(hi_wr), .lo_wr(lo_wr),
    .wr_data(wr_data), .sq_out(sq_out), .tick(tick)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit    q_sq[$];
  bit    q_tk[$];
  string q_tag[$];

  int m_acc  = 0;
  int m_word = 0;
  int m_hi   = 0;

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; run = 1'b0; hi_wr = 1'b0; lo_wr = 1'b0; wr_data = 8'h00;
    repeat (2) @(posedge clk);
    #1;
    m_acc = 0; m_word = 0; m_hi = 0;
    @(negedge clk);
    rst = 1'b0;
    checks++;
    if (sq_out !== 1'b0 || tick !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset outputs: actual sq=%b tick=%b expected sq=0 tick=0", sq_out, tick);
    end
  endtask

  task automatic cyc(input bit r, input bit h, input bit l, input logic [7:0] d, input string tag);
    int st, nacc;
    @(negedge clk);
    run = r; hi_wr = h; lo_wr = l; wr_data = d;
    @(posedge clk);
    #1;
    st   = (m_word >= 32768) ? (65536 - m_word) % 65536 : m_word;
    nacc = r ? (m_acc + st) % 65536 : 0;
    q_sq.push_back(nacc >= 32768);
    q_tk.push_back((nacc >= 32768) && (m_acc < 32768));
    q_tag.push_back(tag);
    m_acc = nacc;
    if (l)      m_word = m_hi * 256 + int'(d);
    else if (h) m_hi = int'(d);
  endtask

  task automatic load(input int w, input bit r, input string tag);
    cyc(r, 1'b1, 1'b0, w[15:8], tag);
    cyc(r, 1'b0, 1'b1, w[7:0], tag);
  endtask

  task automatic spin(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 8'h00, tag);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      while (q_sq.size() > 0) begin
        bit es, et;
        string tg;
        es = q_sq.pop_front();
        et = q_tk.pop_front();
        tg = q_tag.pop_front();
        checks++;
        if (sq_out !== es || tick !== et) begin
          fails++;
          $display("FAIL %s: actual sq=%b tick=%b expected sq=%b tick=%b", tg, sq_out, tick, es, et);
        end
      end
    end
  end

  initial begin
    do_reset();
    spin(4, "R1 idle word");
    // R10: staged high byte cleared by reset
    cyc(1'b0, 1'b1, 1'b0, 8'h40, "R10 stage");
    do_reset();
    cyc(1'b0, 1'b0, 1'b1, 8'h00, "R10 commit");
    spin(6, "R10 word zero");
    // R8 / R5 / R7: power of two
    load(32'h4000, 1'b0, "R3 load");
    spin(16, "R8 quarter-scale square");
    // R2: high write during run does not change rate
    cyc(1'b1, 1'b1, 1'b0, 8'h10, "R2 stage while running");
    spin(6, "R2 rate unchanged");
    // R3: commit takes effect one edge later
    cyc(1'b1, 1'b0, 1'b1, 8'h00, "R3 commit timing");
    spin(20, "R3 new rate");
    // R4: mirrored words
    load(32'hC000, 1'b1, "R4 load C000");
    spin(12, "R4 C000 mirrors");
    load(32'h8000, 1'b1, "R4 load 8000");
    spin(8, "R4 half scale");
    load(32'hFFFF, 1'b1, "R4 load FFFF");
    spin(40, "R4 FFFF steps one");
    load(32'h0123, 1'b1, "R5 load 0123");
    spin(400, "R5 arbitrary word");
    // R6: stop mid-cycle then restart
    cyc(1'b0, 1'b0, 1'b0, 8'h00, "R6 stop");
    cyc(1'b0, 1'b0, 1'b0, 8'h00, "R6 stopped");
    spin(300, "R6 restart from zero");
    // R9: both strobes together
    cyc(1'b1, 1'b1, 1'b0, 8'h20, "R9 stage");
    cyc(1'b1, 1'b1, 1'b1, 8'h00, "R9 both strobes");
    spin(12, "R9 staged high used");
    cyc(1'b1, 1'b0, 1'b1, 8'h00, "R9 staged kept");
    spin(12, "R9 staged high retained");
    load(32'h0800, 1'b1, "R8 load 0800");
    spin(64, "R8 period 32");
    cyc(1'b0, 1'b0, 1'b0, 8'h00, "R6 final stop");
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule